// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Modulator with Pair Joining

This block produces eight pulse-width modulated outputs from one shared input clock. Each channel has its own period and duty registers and its own counter. A channel runs in one of two alignments. In edge mode the pulse starts at the beginning of every period. In symmetric mode the counter runs up and then back down, so the pulse sits in the middle of a period that is twice as long.

Neighbouring channels can be fused in pairs (0 with 1, 2 with 3, 4 with 5, 6 with 7) to form one 16-bit channel. In a fused pair the even channel's byte registers hold the upper half of the value and the odd channel's registers hold the lower half. The odd channel's enable bit, alignment bit and pin control the fused channel, and the even pin stays low.

Software programs the block through a single-cycle register port: a write strobe with address and data, and a combinational read-data output for the presented address. Alignment and joining bits are locked while the channels they affect are running. Period and duty changes are held back until the current period ends, so no pulse is ever cut short.

Top module: `pwm8_concat`

## Requirements
- R1: After reset every register reads 0, every channel is disabled and in edge mode with no pairs joined, and all eight pins are low.
- R2: In edge mode with period P > 0 and duty D, the channel counter runs 0, 1, ..., P-1 and then returns to 0. The pin is high exactly while the count is below D.
- R3: In symmetric mode with period P > 0, the counter runs 0 up to P and then back down to 0, so one output period lasts 2*P cycles. The pin is high exactly while the count is below D. The pin therefore changes level at each point where the count equals D.
- R4: On an enabled channel, a duty of 0 holds the pin low, and a nonzero duty equal to or above the period holds the pin high.
- R5: Join bit k (bit k of the join register at address 0x05) fuses channels 2k and 2k+1 into a 16-bit channel. The 16-bit period is {period[2k], period[2k+1]}, and the duty is built the same way. The fused channel uses enable bit 2k+1, alignment bit 2k+1 and pin 2k+1. Pin 2k stays low.
- R6: A write to alignment bit n is ignored while enable bit n is 1. A write to join bit k is ignored while enable bit 2k or 2k+1 is 1. The ignored bit keeps its old value on readback, and the other bits of the same write are still taken.
- R7: A running channel takes new period and duty values only at the end of its current period: the wrap to 0 in edge mode, or the return to 0 on the way down in symmetric mode. A disabled channel follows the registers at once.
- R8: A channel whose enable bit is 0 drives its pin low and holds its counter at 0.
- R9: Register map: enable at 0x00 (bit n for channel n), alignment at 0x04 (bit n = 1 selects symmetric mode for channel n), join at 0x05 (bits 3:0), period n at 0x08+n, duty n at 0x10+n. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common input clock for all counters and registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, taken on the rising clock edge |
| addr | input | 6 | Register address for both reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr (combinational) |
| pwm_o | output | 8 | PWM pins, bit n for channel n |

## Verification
Each channel is run in edge mode and in symmetric mode, with a duty strictly inside the period. The comparison shows whether the pulse is placed correctly and whether the output period is P or 2*P. Duty values of 0 and above the period test the two saturated levels, which an off-by-one error in the comparator would break. Duty and period are rewritten in the middle of a period to show whether updates wait for the period boundary. Two fused pairs, one in each alignment, with values above 255, test the byte order, the pin that carries the output and the pin that stays low. Alignment and join bits are written while channels are running and then read back, to prove the lock works bit by bit.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int CH    = 8;
  localparam int CW    = 8;
  localparam int NPAIR = CH / 2;
  localparam int CNT_W = 2 * CW;
  localparam int AW    = 6;

  localparam logic [AW-1:0] A_ENABLE = AW'(0);
  localparam logic [AW-1:0] A_ALIGN  = AW'(4);
  localparam logic [AW-1:0] A_JOIN   = AW'(5);
  localparam logic [AW-1:0] A_PER    = AW'(8);
  localparam logic [AW-1:0] A_DUTY   = AW'(16);

  typedef logic [CNT_W-1:0] cnt_t;

  // pin level for a given count, duty and period
  function automatic logic pwm_level(cnt_t cnt, cnt_t duty, cnt_t per);
    if (duty == '0) return 1'b0;
    if (duty >= per) return 1'b1;
    return cnt < duty;
  endfunction

  // edge mode: true on the last count of a period
  function automatic logic edge_wrap(cnt_t cnt, cnt_t per);
    logic [CNT_W:0] nxt;
    nxt = {1'b0, cnt} + 1'b1;
    return nxt >= {1'b0, per};
  endfunction
endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  output logic [CW-1:0]           rdata,
  output logic [CH-1:0]           en_q,
  output logic [CH-1:0]           al_q,
  output logic [NPAIR-1:0]        cc_q,
  output logic [CH-1:0][CW-1:0]   per_q,
  output logic [CH-1:0][CW-1:0]   duty_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      al_q   <= '0;
      cc_q   <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (wr_en) begin
      if (addr == A_ENABLE) en_q <= wdata[CH-1:0];
      if (addr == A_ALIGN) begin
        for (int n = 0; n < CH; n++)
          if (!en_q[n]) al_q[n] <= wdata[n];
      end
      if (addr == A_JOIN) begin
        for (int k = 0; k < NPAIR; k++)
          if (!(en_q[2*k] || en_q[2*k+1])) cc_q[k] <= wdata[k];
      end
      for (int n = 0; n < CH; n++) begin
        if (addr == A_PER + AW'(n))  per_q[n]  <= wdata;
        if (addr == A_DUTY + AW'(n)) duty_q[n] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_ENABLE) rdata = CW'(en_q);
    if (addr == A_ALIGN)  rdata = CW'(al_q);
    if (addr == A_JOIN)   rdata = CW'(cc_q);
    for (int n = 0; n < CH; n++) begin
      if (addr == A_PER + AW'(n))  rdata = per_q[n];
      if (addr == A_DUTY + AW'(n)) rdata = duty_q[n];
    end
  end
endmodule

// File: rtl/pwm8_core.sv
module pwm8_core
  import pwm8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic center,
  input  cnt_t tgt_per,
  input  cnt_t tgt_duty,
  output logic pin,
  output logic load_evt,
  output cnt_t sh_per,
  output cnt_t sh_duty
);
  cnt_t cnt;
  logic down;
  logic ctr_end;

  assign ctr_end  = (sh_per == '0) || (down && cnt == '0);
  assign load_evt = !act || (center ? ctr_end : edge_wrap(cnt, sh_per));
  assign pin      = act && pwm_level(cnt, sh_duty, sh_per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      down    <= 1'b0;
      sh_per  <= '0;
      sh_duty <= '0;
    end else begin
      if (load_evt) begin
        sh_per  <= tgt_per;
        sh_duty <= tgt_duty;
      end
      if (!act) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (!center) begin
        cnt <= edge_wrap(cnt, sh_per) ? '0 : cnt + cnt_t'(1);
      end else if (sh_per == '0) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (!down) begin
        if (cnt >= sh_per) begin
          down <= 1'b1;
          cnt  <= cnt - cnt_t'(1);
        end else begin
          cnt <= cnt + cnt_t'(1);
        end
      end else if (cnt == '0) begin
        down <= 1'b0;
        cnt  <= cnt_t'(1);
      end else begin
        cnt <= cnt - cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/pwm8_concat.sv
module pwm8_concat
  import pwm8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [CH-1:0] pwm_o
);
  logic [CH-1:0]         en_q;
  logic [CH-1:0]         al_q;
  logic [NPAIR-1:0]      cc_q;
  logic [CH-1:0][CW-1:0] per_q;
  logic [CH-1:0][CW-1:0] duty_q;

  // per-core observation points
  logic [CH-1:0] core_act;
  logic [CH-1:0] core_load;
  cnt_t          core_sper  [CH];
  cnt_t          core_sduty [CH];

  pwm8_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .en_q(en_q), .al_q(al_q), .cc_q(cc_q),
    .per_q(per_q), .duty_q(duty_q)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    localparam int EV = 2 * k;
    localparam int OD = 2 * k + 1;
    cnt_t od_per, od_duty;

    assign core_act[EV] = en_q[EV] && !cc_q[k];
    assign core_act[OD] = en_q[OD];
    assign od_per  = cc_q[k] ? {per_q[EV], per_q[OD]}   : cnt_t'(per_q[OD]);
    assign od_duty = cc_q[k] ? {duty_q[EV], duty_q[OD]} : cnt_t'(duty_q[OD]);

    pwm8_core u_even (
      .clk(clk), .rst_n(rst_n), .act(core_act[EV]), .center(al_q[EV]),
      .tgt_per(cnt_t'(per_q[EV])), .tgt_duty(cnt_t'(duty_q[EV])),
      .pin(pwm_o[EV]), .load_evt(core_load[EV]),
      .sh_per(core_sper[EV]), .sh_duty(core_sduty[EV])
    );

    pwm8_core u_odd (
      .clk(clk), .rst_n(rst_n), .act(core_act[OD]), .center(al_q[OD]),
      .tgt_per(od_per), .tgt_duty(od_duty),
      .pin(pwm_o[OD]), .load_evt(core_load[OD]),
      .sh_per(core_sper[OD]), .sh_duty(core_sduty[OD])
    );
  end
endmodule

// File: rtl/pwm8_checker.sv
module pwm8_checker
  import pwm8_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CH-1:0]    pwm_o,
  input logic [CH-1:0]    en_q,
  input logic [CH-1:0]    al_q,
  input logic [NPAIR-1:0] cc_q,
  input logic [CH-1:0]    core_act,
  input logic [CH-1:0]    core_load,
  input cnt_t             core_sper  [CH],
  input cnt_t             core_sduty [CH]
);
  for (genvar n = 0; n < CH; n++) begin : g_ch
    // R6: alignment bit frozen while channel runs
    a_r6_align_locked: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[n] |=> $stable(al_q[n]));
    // R8: disabled channel is quiet
    a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[n] |-> !pwm_o[n]);
    // R4: zero duty gives low pin
    a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (core_act[n] && core_sduty[n] == '0) |-> !pwm_o[n]);
    // R4: saturated duty gives high pin
    a_r4_full_high: assert property (@(posedge clk) disable iff (!rst_n)
      (core_act[n] && core_sduty[n] != '0 && core_sduty[n] >= core_sper[n]) |-> pwm_o[n]);
    // R7: shadows hold between period ends
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (core_act[n] && !core_load[n]) |=> ($stable(core_sper[n]) && $stable(core_sduty[n])));
  end
  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    // R5: even pin of a fused pair stays low
    a_r5_even_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cc_q[k] |-> !pwm_o[2*k]);
    // R6: join bit frozen while either channel runs
    a_r6_join_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[2*k] || en_q[2*k+1]) |=> $stable(cc_q[k]));
  end
endmodule

bind pwm8_concat pwm8_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .en_q(en_q), .al_q(al_q),
  .cc_q(cc_q), .core_act(core_act), .core_load(core_load),
  .core_sper(core_sper), .core_sduty(core_sduty)
);

// File: tb/tb_pwm8_concat.sv
`timescale 1ns/1ps
module tb_pwm8_concat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pwm_o;

  int    n_chk = 0;
  int    n_err = 0;
  string tag = "R1";
  bit    done = 0;

  always #10 clk = ~clk;

  pwm8_concat dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o));

  // behavioural reference state
  bit [7:0] m_en, m_al;
  bit [3:0] m_cc;
  int m_per [8];
  int m_duty [8];
  int m_cnt [8];
  bit m_dn [8];
  int m_sp [8];
  int m_sd [8];

  function automatic bit unit_on(int i);
    if (i % 2 == 1) return m_en[i];
    return m_en[i] && !m_cc[i/2];
  endfunction

  function automatic int want_per(int i);
    if (i % 2 == 1 && m_cc[i/2]) return m_per[i-1] * 256 + m_per[i];
    return m_per[i];
  endfunction

  function automatic int want_duty(int i);
    if (i % 2 == 1 && m_cc[i/2]) return m_duty[i-1] * 256 + m_duty[i];
    return m_duty[i];
  endfunction

  function automatic bit want_pin(int i);
    if (!unit_on(i)) return 0;
    if (m_sd[i] == 0) return 0;
    if (m_sd[i] >= m_sp[i]) return 1;
    return m_cnt[i] < m_sd[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_al = 0; m_cc = 0;
      for (int i = 0; i < 8; i++) begin
        m_per[i] = 0; m_duty[i] = 0; m_cnt[i] = 0; m_dn[i] = 0; m_sp[i] = 0; m_sd[i] = 0;
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit reload;
        reload = 0;
        if (!unit_on(i)) begin
          m_cnt[i] = 0; m_dn[i] = 0; reload = 1;
        end else if (!m_al[i]) begin
          if (m_cnt[i] + 1 >= m_sp[i]) begin m_cnt[i] = 0; reload = 1; end
          else m_cnt[i]++;
        end else if (m_sp[i] == 0) begin
          m_cnt[i] = 0; m_dn[i] = 0; reload = 1;
        end else if (!m_dn[i]) begin
          if (m_cnt[i] >= m_sp[i]) begin m_dn[i] = 1; m_cnt[i]--; end
          else m_cnt[i]++;
        end else if (m_cnt[i] == 0) begin
          m_dn[i] = 0; m_cnt[i] = 1; reload = 1;
        end else m_cnt[i]--;
        if (reload) begin m_sp[i] = want_per(i); m_sd[i] = want_duty(i); end
      end
      if (wr_en) begin
        if (addr == 0) m_en = wdata;
        else if (addr == 4) begin
          for (int n = 0; n < 8; n++) if (!m_en[n]) m_al[n] = wdata[n];
        end else if (addr == 5) begin
          for (int k = 0; k < 4; k++) if (!m_en[2*k] && !m_en[2*k+1]) m_cc[k] = wdata[k];
        end else if (addr >= 8 && addr < 16) m_per[addr-8] = wdata;
        else if (addr >= 16 && addr < 24) m_duty[addr-16] = wdata;
      end
    end
  end

  // compare pins every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 8; i++) begin
        n_chk++;
        if (pwm_o[i] !== want_pin(i)) begin
          n_err++;
          $display("FAIL %s pin%0d actual=%0b expected=%0b at %0t", tag, i, pwm_o[i], want_pin(i), $time);
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string t);
    @(negedge clk);
    addr = 6'(a);
    #2;
    n_chk++;
    if (rdata !== 8'(exp)) begin
      n_err++;
      $display("FAIL %s read addr=%0d actual=%0h expected=%0h", t, a, rdata, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    done = 1;
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values and quiet pins
    tag = "R1";
    rd(0, 0, "R1"); rd(4, 0, "R1"); rd(5, 0, "R1"); rd(11, 0, "R1"); rd(20, 0, "R1");
    run(5);
    // R9: register map readback
    tag = "R9";
    wr(8, 5); wr(16, 2);
    rd(8, 5, "R9"); rd(16, 2, "R9"); rd(40, 0, "R9");
    // R2: edge mode on channel 0
    tag = "R2";
    wr(0, 8'h01); run(40);
    // R3: symmetric mode on channel 1
    tag = "R3";
    wr(9, 4); wr(17, 1); wr(4, 8'h02); rd(4, 8'h02, "R3");
    wr(0, 8'h03); run(40);
    // R4: saturated duties on channels 2 and 3
    tag = "R4";
    wr(10, 6); wr(18, 0); wr(11, 6); wr(19, 9);
    wr(0, 8'h0F); run(30);
    // R6: locked bits while running
    tag = "R6";
    wr(4, 8'h00); rd(4, 8'h02, "R6");
    wr(5, 8'h01); rd(5, 8'h00, "R6");
    wr(4, 8'h12); rd(4, 8'h12, "R6");
    // R7: deferred updates
    tag = "R7";
    run(2); wr(16, 4); run(30); wr(8, 3); run(20);
    wr(17, 3); run(30);
    // R8: disabled pins low
    tag = "R8";
    wr(0, 8'h00); run(20);
    wr(16, 1); wr(0, 8'h01); run(12); wr(0, 8'h00); run(10);
    // R5: fused pairs, edge and symmetric
    tag = "R5";
    wr(12, 8'h01); wr(13, 8'h04); wr(20, 8'h00); wr(21, 8'h82);
    wr(5, 8'h04); rd(5, 8'h04, "R5");
    wr(0, 8'h30); run(600);
    wr(14, 8'h01); wr(15, 8'h06); wr(22, 8'h00); wr(23, 8'h02);
    wr(4, 8'h92); wr(5, 8'h0C); rd(5, 8'h0C, "R5");
    wr(0, 8'hF0); run(600);
    tag = "R6";
    wr(5, 8'h00); rd(5, 8'h0C, "R6");
    run(10);
    done = 1;
    finish_up();
  end
endmodule